// File: doc/BRIEF.md
# Rewindable Synchronous FIFO

This block is a single-clock first-in first-out buffer, 36 bits wide and 512 words deep by default. Both the width and the depth can be changed by parameter. Words are written with a write enable and read with a read enable. Read data is registered and appears one cycle after the read enable. The block reports full, empty and the current number of stored words.

The block also has an active-low rewind strobe. When the strobe is low at a clock edge, the read side goes back to physical address zero. The write side does not move. The stored-word count is then recomputed, so the words between address zero and the write position can be read again in the order they were written. This suits a producer that loads a packet once and may have to replay it, for example after the consumer reports an error.

The rewind is only meaningful while the write position has not wrapped past address zero since reset. If the write position has wrapped, the count after a rewind is clamped to the full depth. Reads and writes must not be issued while the strobe is low. Any that arrive in that cycle are dropped.

Top module: `fifo_rt`

## Requirements
- R1: After reset, level is 0, empty is 1 and full is 0.
- R2: A write while not full stores wrData at the tail and raises level by one. A write while full (with no read) is dropped: level stays at DEPTH and full stays 1.
- R3: A read while not empty presents the oldest stored word on rdData one cycle after the read enable and lowers level by one. A read while empty leaves level at 0 and rdData unchanged.
- R4: A read and a write in the same cycle, while neither full nor empty, leave level unchanged and keep the write order.
- R5: When rtN is low at a clock edge, the next reads return the words from physical address zero onward, in the order they were written.
- R6: A rewind does not move the write position. A write after a rewind lands directly after the last word written before it.
- R7: After a rewind with no wrap, level equals the number of words written since reset.
- R8: A write or read that arrives while rtN is low is ignored. No word is stored, rdData holds, and level follows R7 or R9 alone.
- R9: If the write position has wrapped past address zero since reset, level after a rewind is DEPTH and full is 1.
- R10: full is 1 exactly when level equals DEPTH, empty is 1 exactly when level is 0, and level never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to store |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Registered word, valid the cycle after a read |
| rtN | input | 1 | Rewind strobe, active low |
| full | output | 1 | All DEPTH words are occupied |
| empty | output | 1 | No words are stored |
| level | output | $clog2(DEPTH)+1 | Stored-word count |

## Verification
Two pairs of functions can share a clock edge: a rewind with a read or write, and a read with a write. The bench drives the rewind strobe together with both enables high. It judges that cycle by three results: the level after the edge matches the write count alone, rdData does not change, and the read sequence that follows contains no dropped word. For the read-write pair, it holds both enables high over several cycles in the middle of the buffer. The level must stay flat, and the scoreboard queue must drain in write order.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  // Per-cycle commands from control to the datapath
  typedef struct packed {
    logic push;    // store wrData at the write address
    logic pop;     // load rdData from the read address
    logic rewind;  // read address back to zero
  } fifoStrobe_t;
endpackage

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          rtN,
  input  logic [AW-1:0] wrAddr,
  output fifoStrobe_t   strobe,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam logic [LW-1:0] FULL_COUNT = LW'(DEPTH);
  localparam logic [AW-1:0] LAST_ADDR  = AW'(DEPTH - 1);

  logic [LW-1:0] count;
  logic          wrapped;
  logic          rewind;
  logic          push;
  logic          pop;

  assign rewind = !rtN;
  assign full   = (count == FULL_COUNT);
  assign empty  = (count == '0);
  assign pop    = rdEn && !empty && !rewind;
  assign push   = wrEn && !full && !rewind;

  always_comb begin
    strobe        = '0;
    strobe.push   = push;
    strobe.pop    = pop;
    strobe.rewind = rewind;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      wrapped <= 1'b0;
    end else if (rewind) begin
      count <= wrapped ? FULL_COUNT : {1'b0, wrAddr};
    end else begin
      if (push && wrAddr == LAST_ADDR) wrapped <= 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign level = count;
endmodule

// File: rtl/fifo_rt_data.sv
module fifo_rt_data
  import fifo_rt_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [AW-1:0]     wrAddr
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;

  function automatic logic [AW-1:0] nextAddr(input logic [AW-1:0] a);
    return (a == LAST_ADDR) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextAddr(wrPtr);
      if (strobe.rewind) begin
        rdPtr <= '0;
      end else if (strobe.pop) begin
        rdData <= mem[rdPtr];
        rdPtr  <= nextAddr(rdPtr);
      end
    end
  end

  assign wrAddr = wrPtr;
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              rtN,
  output logic              full,
  output logic              empty,
  output logic [LW-1:0]     level
);
  fifoStrobe_t   strobe;
  logic [AW-1:0] wrAddr;

  fifo_rt_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rtN(rtN),
    .wrAddr(wrAddr), .strobe(strobe), .level(level), .full(full), .empty(empty)
  );

  fifo_rt_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdData(rdData), .wrAddr(wrAddr)
  );
endmodule

// File: rtl/fifo_rt_checker.sv
module fifo_rt_checker #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 512,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              rtN,
  input logic              full,
  input logic              empty,
  input logic [LW-1:0]     level
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (empty && !full && level == '0));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rtN && full && wrEn && !rdEn) |=> (full && $stable(level)));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rtN && empty && rdEn && !wrEn) |=> (empty && $stable(rdData)));

  assert_pushpop_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rtN && wrEn && rdEn && !full && !empty) |=> $stable(level));

  assert_rewind_holds_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!rtN && (wrEn || rdEn)) |=> $stable(rdData));

  assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    (level <= LW'(DEPTH)) && !(full && empty));
endmodule

bind fifo_rt fifo_rt_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk (.*);

// File: tb/fifo_rt_test.sv
module fifo_rt_test;
  localparam int DATA_W = 36;
  localparam int DEPTH  = 512;
  localparam int LW     = $clog2(DEPTH) + 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic              rtN = 1'b1;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              full, empty;
  logic [LW-1:0]     level;

  int checks = 0;
  int fails  = 0;

  // reference model
  logic [DATA_W-1:0] mMem [DEPTH];
  int mWr, mRd, mCount;
  bit mWrapped;
  logic [DATA_W-1:0] expQ [$];
  string             tagQ [$];
  bit pendingCheck = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fifo_rt #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .rtN(rtN), .full(full), .empty(empty), .level(level)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compares rdData against scoreboard after each read
  always @(negedge clk) begin
    if (pendingCheck) begin
      pendingCheck = 1'b0;
      if (expQ.size() > 0) begin
        logic [DATA_W-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, "rdData", longint'(rdData), longint'(e));
      end
    end
  end

  task automatic step(input bit wr, input bit rd, input bit rt,
                      input logic [DATA_W-1:0] d, input string tag);
    bit push, pop;
    @(negedge clk);
    wrEn = wr; rdEn = rd; rtN = !rt; wrData = d;
    @(posedge clk);
    if (rt) begin
      mRd = 0;
      mCount = mWrapped ? DEPTH : mWr;
    end else begin
      pop  = rd && mCount > 0;
      push = wr && mCount < DEPTH;
      if (pop) begin
        expQ.push_back(mMem[mRd]);
        tagQ.push_back(tag);
        mRd = (mRd + 1) % DEPTH;
        pendingCheck = 1'b1;
      end
      if (push) begin
        mMem[mWr] = d;
        if (mWr == DEPTH - 1) mWrapped = 1'b1;
        mWr = (mWr + 1) % DEPTH;
      end
      mCount += int'(push) - int'(pop);
    end
    #2;
    wrEn = 1'b0; rdEn = 1'b0; rtN = 1'b1;
  endtask

  task automatic checkStatus(input string req);
    check(req, "level", longint'(level), longint'(mCount));
    check("R10", "full", longint'(full), longint'(mCount == DEPTH));
    check("R10", "empty", longint'(empty), longint'(mCount == 0));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    mWr = 0; mRd = 0; mCount = 0; mWrapped = 1'b0;
    expQ.delete(); tagQ.delete();
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [DATA_W-1:0] pat(input int i);
    return {4'h5, 32'(i * 32'h9E37 + 7)};
  endfunction

  initial begin
    logic [DATA_W-1:0] held;
    doReset();
    #1;
    check("R1", "level", longint'(level), 0);
    check("R1", "empty", longint'(empty), 1);
    check("R1", "full", longint'(full), 0);

    for (int i = 0; i < 6; i++) step(1, 0, 0, pat(i), "R2");
    checkStatus("R2");
    for (int i = 0; i < 3; i++) step(0, 1, 0, '0, "R3");
    checkStatus("R3");

    for (int i = 6; i < 10; i++) step(1, 1, 0, pat(i), "R4");
    checkStatus("R4");

    for (int i = 0; i < 4; i++) step(0, 1, 0, '0, "R3");
    step(0, 0, 0, '0, "R3");
    held = rdData;
    step(0, 1, 0, '0, "R3");
    step(0, 0, 0, '0, "R3");
    checkStatus("R3");
    check("R3", "rdData on empty read", longint'(rdData), longint'(held));

    // rewind with both enables high: both dropped
    held = rdData;
    step(1, 1, 1, 36'hBAD, "R8");
    checkStatus("R7");
    check("R8", "level after rewind", longint'(level), 10);
    check("R8", "rdData held", longint'(rdData), longint'(held));

    // replay from address zero, then append
    for (int i = 0; i < 4; i++) step(0, 1, 0, '0, "R5");
    step(1, 0, 0, pat(100), "R6");
    checkStatus("R6");
    for (int i = 0; i < 7; i++) step(0, 1, 0, '0, "R6");
    step(0, 0, 0, '0, "R6");
    checkStatus("R6");

    // fill to full, overflow, wrap, rewind clamp
    doReset();
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, pat(i + 200), "R2");
    checkStatus("R10");
    step(1, 0, 0, 36'h123, "R2");
    checkStatus("R2");
    step(0, 1, 0, '0, "R3");
    step(1, 0, 0, pat(999), "R9");
    step(0, 0, 1, '0, "R9");
    checkStatus("R9");
    check("R9", "full after clamp", longint'(full), 1);
    step(0, 0, 0, '0, "R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule